// File: doc/BRIEF.md
# Memory Operand Form Length Decoder

This block sits in an instruction length and operand decode path. It receives the operand-form byte that follows an opcode, together with the effective address width in force (16 or 32 bit). It splits that byte into its three fields and works out how many bytes of the operand specifier remain: whether a scaled-index byte comes next, and how long the displacement is. It also reports whether the operand is a register or a memory location, which segment a memory form uses by default, and whether the displacement must be sign-extended.

Results are registered and appear one cycle after the operand-form strobe. When the 32-bit map asks for a scaled-index byte, the block holds a pending status and raises no result. A second strobe then delivers the scaled-index byte, and the block completes the decode one cycle after it. It decodes that byte into its scale, index and base fields, the multiplier, and the absent-base and absent-index cases. The block computes no addresses and reads no registers.

Top module: `addr_form_decoder`

## Requirements
- R1: While reset (rst_n low) is applied, out_valid and sib_pending are 0 after the next clock edge.
- R2: One cycle after an accepted modrm_valid strobe, md_field = byte[7:6], regop_field = byte[5:3] and rm_field = byte[2:0]. out_valid pulses for one cycle unless a scaled-index byte is required.
- R3: md_field = 11b selects a register in either address width: is_reg = 1, disp_len = 0, need_sib = 0, seg_ss = 0.
- R4: With addr32 = 0, disp_len is 2 for md 00 with rm 110, 0 for other md 00 forms, 1 for md 01 and 2 for md 10. need_sib is never set.
- R5: With addr32 = 0, seg_ss = 1 (stack segment) for memory forms with rm 010 or 011, and for rm 110 with md 01 or 10. All other forms give seg_ss = 0 (data segment).
- R6: With addr32 = 1 and rm other than 100, disp_len is 4 for md 00 with rm 101, 0 for other md 00 forms, 1 for md 01 and 4 for md 10.
- R7: With addr32 = 1, rm = 100 and md other than 11, sib_pending = 1 and out_valid = 0 one cycle after the strobe. One cycle after the sib_valid strobe, out_valid = 1, sib_pending = 0 and need_sib = 1.
- R8: The scaled-index byte splits into sc_field = [7:6], idx_field = [5:3] and bs_field = [2:0], with scale_mul = 1, 2, 4 or 8 for sc_field 0 to 3. Forms without that byte report scale_mul = 1 and zero in these fields.
- R9: With a scaled-index byte, disp_len is 1 for md 01 and 4 for md 10. For md 00 it is 4 when the base field is 101 (and base_absent = 1), else 0. An index field of 100 gives index_absent = 1.
- R10: With addr32 = 1, seg_ss = 1 when the base is the frame or stack pointer. That covers rm 101 with md 01/10 and no scaled-index byte, a base field of 100, or a base field of 101 with md 01/10.
- R11: disp_sext = 1 exactly when disp_len = 1.
- R12: Two strobes are ignored: sib_valid while no scaled-index byte is pending, and modrm_valid while one is pending. Neither produces out_valid, and every field output stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modrm_valid | input | 1 | Operand-form byte strobe |
| modrm_byte | input | 8 | Operand-form byte |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit |
| sib_valid | input | 1 | Scaled-index byte strobe |
| sib_byte | input | 8 | Scaled-index byte |
| out_valid | output | 1 | Decode complete pulse |
| sib_pending | output | 1 | Waiting for scaled-index byte |
| is_reg | output | 1 | Operand is a register |
| need_sib | output | 1 | Form used a scaled-index byte |
| md_field | output | 2 | Mode field |
| regop_field | output | 3 | Register/opcode-extension field |
| rm_field | output | 3 | Register/memory field |
| sc_field | output | 2 | Scale field |
| idx_field | output | 3 | Index field |
| bs_field | output | 3 | Base field |
| scale_mul | output | 4 | Scale multiplier 1/2/4/8 |
| disp_len | output | 3 | Displacement length in bytes |
| disp_sext | output | 1 | Displacement is sign-extended |
| seg_ss | output | 1 | 1 = stack segment default, 0 = data segment |
| base_absent | output | 1 | No base register |
| index_absent | output | 1 | No index register |

## Verification
The bench sweeps all 256 operand-form bytes in both address widths. This separates the 16-bit map from the 32-bit map, including the displacement-only special case in each and the scaled-index request in the wide map. All 256 scaled-index bytes are then sent under each of the three memory modes. This distinguishes the absent-base case (md 00 only) from the frame-pointer base, and the stack-pointer base from the absent index. Stray strobes in both states show that they are ignored.

// File: rtl/afd_pkg.sv
package afd_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 3;
  localparam int MOD_W   = 2;
  localparam int LEN_W   = 3;
  localparam int MUL_W   = 1 << MOD_W;

  localparam logic [MOD_W-1:0]   MD_REG     = 2'b11;
  localparam logic [MOD_W-1:0]   MD_NODISP  = 2'b00;
  localparam logic [MOD_W-1:0]   MD_D8      = 2'b01;
  localparam logic [FIELD_W-1:0] RM_ESC_SIB = 3'b100;
  localparam logic [FIELD_W-1:0] RM_ABS32   = 3'b101;
  localparam logic [FIELD_W-1:0] RM_ABS16   = 3'b110;
  localparam logic [FIELD_W-1:0] IDX_NONE   = 3'b100;
  localparam logic [FIELD_W-1:0] BS_STACK   = 3'b100;
  localparam logic [FIELD_W-1:0] BS_FRAME   = 3'b101;

  // displacement bytes, 16-bit map
  function automatic logic [LEN_W-1:0] len_narrow(logic [MOD_W-1:0] m, logic [FIELD_W-1:0] rm);
    case (m)
      2'b00:   len_narrow = (rm == RM_ABS16) ? 3'd2 : 3'd0;
      2'b01:   len_narrow = 3'd1;
      2'b10:   len_narrow = 3'd2;
      default: len_narrow = 3'd0;
    endcase
  endfunction

  // displacement bytes, 32-bit map without scaled-index byte
  function automatic logic [LEN_W-1:0] len_wide(logic [MOD_W-1:0] m, logic [FIELD_W-1:0] rm);
    case (m)
      2'b00:   len_wide = (rm == RM_ABS32) ? 3'd4 : 3'd0;
      2'b01:   len_wide = 3'd1;
      2'b10:   len_wide = 3'd4;
      default: len_wide = 3'd0;
    endcase
  endfunction

  // displacement bytes when a scaled-index byte is present
  function automatic logic [LEN_W-1:0] len_sib(logic [MOD_W-1:0] m, logic [FIELD_W-1:0] bs);
    case (m)
      2'b00:   len_sib = (bs == BS_FRAME) ? 3'd4 : 3'd0;
      2'b01:   len_sib = 3'd1;
      default: len_sib = 3'd4;
    endcase
  endfunction

  function automatic logic ss_narrow(logic [MOD_W-1:0] m, logic [FIELD_W-1:0] rm);
    if (m == MD_REG) ss_narrow = 1'b0;
    else if (rm == 3'b010 || rm == 3'b011) ss_narrow = 1'b1;
    else ss_narrow = (rm == RM_ABS16) && (m != MD_NODISP);
  endfunction

  function automatic logic ss_wide(logic [MOD_W-1:0] m, logic [FIELD_W-1:0] rm);
    ss_wide = (m != MD_REG) && (m != MD_NODISP) && (rm == RM_ABS32);
  endfunction

  function automatic logic ss_sib(logic [MOD_W-1:0] m, logic [FIELD_W-1:0] bs);
    ss_sib = (bs == BS_STACK) || ((bs == BS_FRAME) && (m != MD_NODISP));
  endfunction

  function automatic logic [MUL_W-1:0] scale_of(logic [MOD_W-1:0] s);
    scale_of = MUL_W'(1) << s;
  endfunction

  function automatic logic sext_of(logic [MOD_W-1:0] m);
    sext_of = (m == MD_D8);
  endfunction
endpackage

// File: rtl/afd_modrm_dec.sv
module afd_modrm_dec
  import afd_pkg::*;
(
  input  logic [BYTE_W-1:0]  modrm,
  input  logic               wide,
  output logic [MOD_W-1:0]   md,
  output logic [FIELD_W-1:0] regop,
  output logic [FIELD_W-1:0] rm,
  output logic               reg_form,
  output logic               sib_req,
  output logic [LEN_W-1:0]   dlen,
  output logic               ss_def,
  output logic               sext
);
  assign md    = modrm[7:6];
  assign regop = modrm[5:3];
  assign rm    = modrm[2:0];

  always_comb begin
    reg_form = (md == MD_REG);
    sib_req  = wide && !reg_form && (rm == RM_ESC_SIB);
    sext     = sext_of(md);
    if (wide) begin
      dlen   = len_wide(md, rm);
      ss_def = ss_wide(md, rm);
    end else begin
      dlen   = len_narrow(md, rm);
      ss_def = ss_narrow(md, rm);
    end
  end
endmodule

// File: rtl/afd_sib_dec.sv
module afd_sib_dec
  import afd_pkg::*;
(
  input  logic [BYTE_W-1:0]  sib,
  input  logic [MOD_W-1:0]   md,
  output logic [MOD_W-1:0]   sc,
  output logic [FIELD_W-1:0] idx,
  output logic [FIELD_W-1:0] bs,
  output logic [MUL_W-1:0]   mul,
  output logic [LEN_W-1:0]   dlen,
  output logic               ss_def,
  output logic               no_base,
  output logic               no_index
);
  assign sc  = sib[7:6];
  assign idx = sib[5:3];
  assign bs  = sib[2:0];

  always_comb begin
    mul      = scale_of(sc);
    dlen     = len_sib(md, bs);
    ss_def   = ss_sib(md, bs);
    no_base  = (md == MD_NODISP) && (bs == BS_FRAME);
    no_index = (idx == IDX_NONE);
  end
endmodule

// File: rtl/afd_ctrl.sv
module afd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic modrm_valid,
  input  logic sib_valid,
  input  logic sib_req,
  output logic take_modrm,
  output logic take_sib,
  output logic pending,
  output logic done
);
  logic pend_q, done_q;

  assign take_modrm = modrm_valid && !pend_q;
  assign take_sib   = sib_valid && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (take_modrm && !sib_req) || take_sib;
      if (take_sib) pend_q <= 1'b0;
      else if (take_modrm && sib_req) pend_q <= 1'b1;
    end
  end

  assign pending = pend_q;
  assign done    = done_q;
endmodule

// File: rtl/addr_form_decoder.sv
module addr_form_decoder
  import afd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        modrm_valid,
  input  logic [7:0]  modrm_byte,
  input  logic        addr32,
  input  logic        sib_valid,
  input  logic [7:0]  sib_byte,
  output logic        out_valid,
  output logic        sib_pending,
  output logic        is_reg,
  output logic        need_sib,
  output logic [1:0]  md_field,
  output logic [2:0]  regop_field,
  output logic [2:0]  rm_field,
  output logic [1:0]  sc_field,
  output logic [2:0]  idx_field,
  output logic [2:0]  bs_field,
  output logic [3:0]  scale_mul,
  output logic [2:0]  disp_len,
  output logic        disp_sext,
  output logic        seg_ss,
  output logic        base_absent,
  output logic        index_absent
);
  // modrm decode wires
  logic [MOD_W-1:0]   m_md;
  logic [FIELD_W-1:0] m_regop, m_rm;
  logic               m_reg, m_sib_req, m_ss, m_sext;
  logic [LEN_W-1:0]   m_dlen;
  // sib decode wires
  logic [MOD_W-1:0]   s_sc;
  logic [FIELD_W-1:0] s_idx, s_bs;
  logic [MUL_W-1:0]   s_mul;
  logic [LEN_W-1:0]   s_dlen;
  logic               s_ss, s_nobase, s_noidx;
  // control events
  logic take_modrm, take_sib, pending, done;

  // held state
  logic [MOD_W-1:0]   md_q;
  logic [FIELD_W-1:0] regop_q, rm_q, idx_q, bs_q;
  logic [MOD_W-1:0]   sc_q;
  logic [MUL_W-1:0]   mul_q;
  logic [LEN_W-1:0]   dlen_q;
  logic               reg_q, sib_q, ss_q, sext_q, nobase_q, noidx_q, wide_q;

  afd_modrm_dec u_mdec (
    .modrm(modrm_byte), .wide(addr32), .md(m_md), .regop(m_regop), .rm(m_rm),
    .reg_form(m_reg), .sib_req(m_sib_req), .dlen(m_dlen), .ss_def(m_ss), .sext(m_sext)
  );

  afd_sib_dec u_sdec (
    .sib(sib_byte), .md(md_q), .sc(s_sc), .idx(s_idx), .bs(s_bs), .mul(s_mul),
    .dlen(s_dlen), .ss_def(s_ss), .no_base(s_nobase), .no_index(s_noidx)
  );

  afd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .modrm_valid(modrm_valid), .sib_valid(sib_valid),
    .sib_req(m_sib_req), .take_modrm(take_modrm), .take_sib(take_sib),
    .pending(pending), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md_q     <= '0;
      regop_q  <= '0;
      rm_q     <= '0;
      sc_q     <= '0;
      idx_q    <= '0;
      bs_q     <= '0;
      mul_q    <= MUL_W'(1);
      dlen_q   <= '0;
      reg_q    <= 1'b0;
      sib_q    <= 1'b0;
      ss_q     <= 1'b0;
      sext_q   <= 1'b0;
      nobase_q <= 1'b0;
      noidx_q  <= 1'b0;
      wide_q   <= 1'b0;
    end else if (take_modrm) begin
      md_q     <= m_md;
      regop_q  <= m_regop;
      rm_q     <= m_rm;
      sc_q     <= '0;
      idx_q    <= '0;
      bs_q     <= '0;
      mul_q    <= MUL_W'(1);
      dlen_q   <= m_dlen;
      reg_q    <= m_reg;
      sib_q    <= m_sib_req;
      ss_q     <= m_ss;
      sext_q   <= m_sext;
      nobase_q <= 1'b0;
      noidx_q  <= 1'b0;
      wide_q   <= addr32;
    end else if (take_sib) begin
      sc_q     <= s_sc;
      idx_q    <= s_idx;
      bs_q     <= s_bs;
      mul_q    <= s_mul;
      dlen_q   <= s_dlen;
      ss_q     <= s_ss;
      nobase_q <= s_nobase;
      noidx_q  <= s_noidx;
    end
  end

  assign out_valid    = done;
  assign sib_pending  = pending;
  assign is_reg       = reg_q;
  assign need_sib     = sib_q;
  assign md_field     = md_q;
  assign regop_field  = regop_q;
  assign rm_field     = rm_q;
  assign sc_field     = sc_q;
  assign idx_field    = idx_q;
  assign bs_field     = bs_q;
  assign scale_mul    = mul_q;
  assign disp_len     = dlen_q;
  assign disp_sext    = sext_q;
  assign seg_ss       = ss_q;
  assign base_absent  = nobase_q;
  assign index_absent = noidx_q;
endmodule

// File: rtl/afd_checker.sv
module afd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       modrm_valid,
  input logic       sib_valid,
  input logic       out_valid,
  input logic       sib_pending,
  input logic       is_reg,
  input logic       need_sib,
  input logic [2:0] disp_len,
  input logic       disp_sext,
  input logic [3:0] scale_mul,
  input logic       wide_mode
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !sib_pending));

  assert_done_not_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !sib_pending);

  assert_pending_from_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sib_pending && !$past(sib_pending)) |-> $past(modrm_valid));

  assert_reg_no_disp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && is_reg) |-> (disp_len == 3'd0 && !need_sib));

  assert_narrow_no_sib_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_mode) |-> (!need_sib && disp_len != 3'd4));

  assert_scale_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(scale_mul) == 1));

  assert_sext_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (disp_sext == (disp_len == 3'd1)));

  assert_stray_sib_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sib_valid && !sib_pending && !modrm_valid) |=> !out_valid);
endmodule

bind addr_form_decoder afd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .modrm_valid(modrm_valid), .sib_valid(sib_valid),
  .out_valid(out_valid), .sib_pending(sib_pending), .is_reg(is_reg),
  .need_sib(need_sib), .disp_len(disp_len), .disp_sext(disp_sext),
  .scale_mul(scale_mul), .wide_mode(wide_q)
);

// File: tb/addr_form_decoder_tb.sv
`timescale 1ns/1ps
module addr_form_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modrm_valid = 1'b0, addr32 = 1'b0, sib_valid = 1'b0;
  logic [7:0] modrm_byte = 8'h00, sib_byte = 8'h00;
  logic out_valid, sib_pending, is_reg, need_sib, disp_sext, seg_ss, base_absent, index_absent;
  logic [1:0] md_field, sc_field;
  logic [2:0] regop_field, rm_field, idx_field, bs_field, disp_len;
  logic [3:0] scale_mul;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  addr_form_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .modrm_valid(modrm_valid), .modrm_byte(modrm_byte),
    .addr32(addr32), .sib_valid(sib_valid), .sib_byte(sib_byte),
    .out_valid(out_valid), .sib_pending(sib_pending), .is_reg(is_reg), .need_sib(need_sib),
    .md_field(md_field), .regop_field(regop_field), .rm_field(rm_field),
    .sc_field(sc_field), .idx_field(idx_field), .bs_field(bs_field),
    .scale_mul(scale_mul), .disp_len(disp_len), .disp_sext(disp_sext), .seg_ss(seg_ss),
    .base_absent(base_absent), .index_absent(index_absent)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_modrm(logic [7:0] b, logic w);
    @(negedge clk);
    modrm_valid = 1'b1; modrm_byte = b; addr32 = w;
    @(negedge clk);
    modrm_valid = 1'b0;
  endtask

  task automatic send_sib(logic [7:0] b);
    @(negedge clk);
    sib_valid = 1'b1; sib_byte = b;
    @(negedge clk);
    sib_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 sib_pending", sib_pending, 0);
    rst_n = 1'b1;

    // full operand-form sweep in both widths
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < 256; i++) begin
        logic [7:0] b;
        int m, r, exp_len, exp_ss;
        b = i[7:0];
        m = i / 64; r = i % 8;
        send_modrm(b, w[0]);
        check("R2 md", md_field, m);
        check("R2 regop", regop_field, (i / 8) % 8);
        check("R2 rm", rm_field, r);
        if (w == 1 && r == 4 && m != 3) begin
          check("R7 pending", sib_pending, 1);
          check("R7 no result", out_valid, 0);
          send_sib(8'h00);
          check("R7 done", out_valid, 1);
          check("R7 cleared", sib_pending, 0);
          check("R7 need_sib", need_sib, 1);
        end else begin
          check("R2 out_valid", out_valid, 1);
          check("R3 is_reg", is_reg, (m == 3) ? 1 : 0);
          check("R4 need_sib", need_sib, 0);
          if (m == 3) begin
            exp_len = 0; exp_ss = 0;
          end else if (w == 0) begin
            exp_len = (m == 0) ? ((r == 6) ? 2 : 0) : 2 * m - (m == 1 ? 1 : 0) * 1;
            if (m == 2) exp_len = 2;
            exp_ss = (r == 2 || r == 3 || (r == 6 && m > 0)) ? 1 : 0;
          end else begin
            exp_len = (m == 0) ? ((r == 5) ? 4 : 0) : ((m == 1) ? 1 : 4);
            exp_ss = (r == 5 && m > 0) ? 1 : 0;
          end
          check(w ? "R6 disp_len" : "R4 disp_len", disp_len, exp_len);
          check(w ? "R10 seg" : "R5 seg", seg_ss, exp_ss);
          check("R11 sext", disp_sext, (exp_len == 1) ? 1 : 0);
          check("R8 unit scale", scale_mul, 1);
          check("R8 zero fields", {sc_field, idx_field, bs_field}, 0);
        end
      end
    end

    // scaled-index byte sweep under each memory mode
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 256; s++) begin
        logic [7:0] mb, sb;
        int sc, ix, bs, exp_len;
        mb = 8'((m * 64) + 8 * (s % 8) + 4);
        sb = s[7:0];
        sc = s / 64; ix = (s / 8) % 8; bs = s % 8;
        send_modrm(mb, 1'b1);
        send_sib(sb);
        check("R7 out_valid", out_valid, 1);
        check("R8 sc", sc_field, sc);
        check("R8 idx", idx_field, ix);
        check("R8 bs", bs_field, bs);
        check("R8 mul", scale_mul, (sc == 0) ? 1 : (sc == 1) ? 2 : (sc == 2) ? 4 : 8);
        exp_len = (m == 1) ? 1 : (m == 2) ? 4 : ((bs == 5) ? 4 : 0);
        check("R9 disp_len", disp_len, exp_len);
        check("R9 base_absent", base_absent, (m == 0 && bs == 5) ? 1 : 0);
        check("R9 index_absent", index_absent, (ix == 4) ? 1 : 0);
        check("R10 seg", seg_ss, (bs == 4 || (bs == 5 && m != 0)) ? 1 : 0);
        check("R11 sext", disp_sext, (exp_len == 1) ? 1 : 0);
      end
    end

    // R12: stray scaled-index strobe after a completed decode
    send_modrm(8'h44, 1'b1);
    send_sib(8'hD5);
    send_sib(8'h2A);
    check("R12 stray sib no result", out_valid, 0);
    check("R12 stray sib sc kept", sc_field, 3);
    check("R12 stray sib bs kept", bs_field, 5);
    check("R12 stray sib len kept", disp_len, 1);

    // R12: operand-form strobe while pending
    send_modrm(8'h0C, 1'b1);
    send_modrm(8'hC0, 1'b0);
    check("R12 pending kept", sib_pending, 1);
    check("R12 no result", out_valid, 0);
    check("R12 is_reg kept", is_reg, 0);
    check("R12 md kept", md_field, 0);
    check("R12 regop kept", regop_field, 1);
    send_sib(8'h25);
    check("R12 completes", out_valid, 1);
    check("R9 abs disp", disp_len, 4);
    check("R9 no base", base_absent, 1);
    check("R9 no index", index_absent, 1);

    // R1: reset mid-pending
    send_modrm(8'h84, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 pending cleared", sib_pending, 0);
    check("R1 out_valid cleared", out_valid, 0);
    rst_n = 1'b1;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule